// File: doc/BRIEF.md
# Spare-Area Block Tag Codec

This block reads and writes the small tag that marks a flash erase block in its spare area: a health status and a logical block number. The decoder takes the spare-area bytes of one block as an indexed byte stream between a start strobe and a byte flagged as the last one. After the last byte it reports the block's health, a 10-bit logical number, and two flags: one for an unreadable tag and one for a block that has no logical number assigned.

The logical number is stored three times, so the decoder picks the first pair of copies that agree and then checks even parity over the whole 16-bit word. The two health bytes are judged by a tolerant vote on their set bits, so a few flipped bits do not change a block's health. The encoder works the other way. From a health code and a logical number it builds a complete spare-area image in one combinational step. The tag copies, both health bytes and the error-correction byte slots are filled in, and every other byte is 0xFF. The positions of the two health bytes are parameters, so one design serves several device layouts.

Top module: `blk_tag_codec`

## Requirements
- R1: The decoder forms copy 0 from bytes 8 (low) and 9 (high), copy 1 from bytes 10/11 and copy 2 from bytes 12/13. It uses the first agreeing pair in the order 0-1, 1-2, 2-0. If no pair agrees, `dec_invalid` is 1 with `dec_logno` = 0 and `dec_unassigned` = 0. The order in which bytes arrive does not matter, only their index.
- R2: If the chosen word has an odd number of set bits over all 16 bits, `dec_invalid` is 1.
- R3: A valid word of 0xFFFF sets `dec_unassigned` = 1 with `dec_logno` = 0. Any other valid word gives `dec_logno` = word bits 10:1, and bits 15:11 of the word are ignored.
- R4: A health byte counts as good when at least GOOD_MIN (default 7) of its 8 bits are set, and as bad otherwise.
- R5: `dec_health` is 2 (factory-bad) if the byte at FBAD_POS (default 5) is bad. Otherwise it is 1 (runtime-bad) if the byte at RBAD_POS (default 4) is bad. Otherwise it is 0 (normal). The value 3 never appears.
- R6: `dec_start` clears all captured bytes and opens a frame (`dec_busy` = 1). A byte with `dec_valid` and `dec_last` closes the frame. `dec_done` is high for exactly one cycle, on the second rising edge after the edge that accepts the last byte. The results change only at that edge and are held until the next frame completes. A new start before the last byte discards the frame in progress.
- R7: Bytes offered when no frame is open do not change the results and raise no `dec_done`. A tag or health byte that is not delivered in a frame counts as 0xFF.
- R8: The encoder builds a word from logical bits 9:0 shifted left by one, ORs in 0x1000, and sets bit 0 so that total parity is even. It writes the low byte at 8, 10 and 12 and the high byte at 9, 11 and 13.
- R9: Encoder health code 0 writes 0xFF to both health bytes. Code 1 writes 0xFF at FBAD_POS and 0x00 at RBAD_POS. Code 2 writes 0x00 to both. Code 3 is treated like code 0.
- R10: Image byte k sits at `enc_image[8k+7:8k]`. The error-correction slots 0-3, 6 and 7, and every byte not named in R8 or R9, are 0xFF.
- R11: After reset `dec_busy`, `dec_done`, `dec_health`, `dec_invalid`, `dec_unassigned` and `dec_logno` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_start | input | 1 | Opens a decode frame and clears captured bytes |
| dec_valid | input | 1 | A spare-area byte is offered |
| dec_idx | input | IDX_W (4) | Byte index within the spare area |
| dec_data | input | 8 | Byte value |
| dec_last | input | 1 | With dec_valid, marks the final byte of the frame |
| dec_busy | output | 1 | A frame is open |
| dec_done | output | 1 | One-cycle pulse: results updated |
| dec_health | output | 2 | 0 normal, 1 runtime-bad, 2 factory-bad |
| dec_invalid | output | 1 | No agreeing copy pair, or parity error |
| dec_unassigned | output | 1 | Tag word was 0xFFFF |
| dec_logno | output | 10 | Decoded logical block number |
| enc_health | input | 2 | Health code to encode |
| enc_logno | input | 10 | Logical block number to encode |
| enc_image | output | OOB_BYTES*8 (128) | Encoded spare-area image, byte k at bits 8k+7:8k |

## Verification
The bench goes after several corner cases that each catch a particular mistake.
- A vector for each agreeing pair (0-1, 1-2 and 2-0) and one where all three copies differ. A decoder that only compared one pair, or fell back to a copy, would return a number where invalid is due.
- Words with even and odd parity and words with junk in bits 15:11. These catch a missing parity check and a mask that is too wide.
- Health bytes with exactly seven and exactly six set bits. An exact compare against 0xFF, or a threshold off by one, would misclassify them.
- Factory-bad together with runtime-bad. This shows that the factory byte takes priority.
- The exact `dec_done` cycle, bytes offered outside a frame, frames with missing bytes, frames sent in reverse order, and a restart in mid-frame. These expose a decoder that latches stray bytes or keeps stale ones.
- Encoder images for every health code, each fed back through the decoder.

// File: rtl/sat_pkg.sv
package sat_pkg;
   localparam int TAG_COPIES = 3;
   localparam int TAG_BASE   = 8;
   localparam int LOGNO_W    = 10;
   localparam logic [15:0] TAG_MARK  = 16'h1000;
   localparam logic [15:0] TAG_EMPTY = 16'hFFFF;

   typedef enum logic [1:0] {
      HLTH_OK      = 2'd0,
      HLTH_WORN    = 2'd1,
      HLTH_FACTORY = 2'd2
   } health_e;
endpackage

// File: rtl/sat_status_vote.sv
module sat_status_vote #(
   parameter int GOOD_MIN = 7
) (
   input  logic [7:0] byte_in,
   output logic       good
);
   if (GOOD_MIN < 1 || GOOD_MIN > 8) begin : g_bad_min
      $error("sat_status_vote: GOOD_MIN must be 1..8");
   end

   logic [3:0] ones;

   always_comb begin
      ones = 4'd0;
      for (int b = 0; b < 8; b++) begin
         ones = ones + {3'd0, byte_in[b]};
      end
   end

   assign good = (ones >= 4'(GOOD_MIN));
endmodule

// File: rtl/sat_tag_decoder.sv
module sat_tag_decoder
   import sat_pkg::*;
#(
   parameter int OOB_BYTES = 16,
   parameter int FBAD_POS  = 5,
   parameter int RBAD_POS  = 4,
   parameter int GOOD_MIN  = 7,
   localparam int IDX_W    = $clog2(OOB_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               valid,
   input  logic [IDX_W-1:0]   idx,
   input  logic [7:0]         data,
   input  logic               last,
   output logic               busy,
   output logic               done,
   output logic [1:0]         health,
   output logic               invalid,
   output logic               unassigned,
   output logic [LOGNO_W-1:0] logno
);
   localparam int TAG_BYTES = 2 * TAG_COPIES;

   // capture state
   logic [7:0] tag_q [TAG_BYTES];
   logic [7:0] fb_q;
   logic [7:0] rb_q;
   logic       busy_q;
   logic       pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAG_BYTES; i++) tag_q[i] <= 8'hFF;
         fb_q   <= 8'hFF;
         rb_q   <= 8'hFF;
         busy_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= 1'b0;
         if (start) begin
            for (int i = 0; i < TAG_BYTES; i++) tag_q[i] <= 8'hFF;
            fb_q   <= 8'hFF;
            rb_q   <= 8'hFF;
            busy_q <= 1'b1;
         end else if (busy_q && valid) begin
            for (int i = 0; i < TAG_BYTES; i++) begin
               if (idx == IDX_W'(TAG_BASE + i)) tag_q[i] <= data;
            end
            if (idx == IDX_W'(FBAD_POS)) fb_q <= data;
            if (idx == IDX_W'(RBAD_POS)) rb_q <= data;
            if (last) begin
               busy_q <= 1'b0;
               pend_q <= 1'b1;
            end
         end
      end
   end

   // copy assembly and pairwise agreement
   logic [15:0]           copy_w [TAG_COPIES];
   logic [TAG_COPIES-1:0] agree;

   for (genvar g = 0; g < TAG_COPIES; g++) begin : g_copy
      assign copy_w[g] = {tag_q[2*g+1], tag_q[2*g]};
      assign agree[g]  = (copy_w[g] == copy_w[(g + 1) % TAG_COPIES]);
   end

   logic [15:0] pick_w;
   logic        found;

   always_comb begin
      found  = 1'b0;
      pick_w = TAG_EMPTY;
      for (int g = 0; g < TAG_COPIES; g++) begin
         if (!found && agree[g]) begin
            found  = 1'b1;
            pick_w = copy_w[g];
         end
      end
   end

   logic               inv_c;
   logic               una_c;
   logic [LOGNO_W-1:0] logno_c;

   assign inv_c   = !found || (^pick_w);
   assign una_c   = !inv_c && (pick_w == TAG_EMPTY);
   assign logno_c = (inv_c || una_c) ? '0 : pick_w[LOGNO_W:1];

   // health votes
   logic [7:0] vote_in [2];
   logic [1:0] vote_good;

   assign vote_in[0] = fb_q;
   assign vote_in[1] = rb_q;

   for (genvar v = 0; v < 2; v++) begin : g_vote
      sat_status_vote #(.GOOD_MIN(GOOD_MIN)) u_vote (
         .byte_in (vote_in[v]),
         .good    (vote_good[v])
      );
   end

   health_e health_c;

   always_comb begin
      if (!vote_good[0])      health_c = HLTH_FACTORY;
      else if (!vote_good[1]) health_c = HLTH_WORN;
      else                    health_c = HLTH_OK;
   end

   // result register
   logic [1:0]         health_q;
   logic               inv_q;
   logic               una_q;
   logic [LOGNO_W-1:0] logno_q;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         health_q <= 2'd0;
         inv_q    <= 1'b0;
         una_q    <= 1'b0;
         logno_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= pend_q;
         if (pend_q) begin
            health_q <= health_c;
            inv_q    <= inv_c;
            una_q    <= una_c;
            logno_q  <= logno_c;
         end
      end
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign health     = health_q;
   assign invalid    = inv_q;
   assign unassigned = una_q;
   assign logno      = logno_q;

   AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && valid && last && !start) |=> ##1 done_q); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> $stable({health_q, inv_q, una_q, logno_q})); // R6
   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !pend_q) |=> !done_q); // R7
   AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      inv_q |-> (logno_q == '0 && !una_q)); // R1
   AST_UNASSIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      una_q |-> (logno_q == '0)); // R3
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      health_q != 2'd3); // R5
endmodule

// File: rtl/sat_tag_encoder.sv
module sat_tag_encoder
   import sat_pkg::*;
#(
   parameter int OOB_BYTES = 16,
   parameter int FBAD_POS  = 5,
   parameter int RBAD_POS  = 4
) (
   input  logic [1:0]             health,
   input  logic [LOGNO_W-1:0]     logno,
   output logic [OOB_BYTES*8-1:0] image
);
   logic [15:0] word;

   always_comb begin
      word    = TAG_MARK | {5'd0, logno, 1'b0};
      word[0] = ^word[15:1];
   end

   always_comb begin
      image = '1;
      for (int k = 0; k < TAG_COPIES; k++) begin
         image[(TAG_BASE + 2*k) * 8 +: 8]     = word[7:0];
         image[(TAG_BASE + 2*k + 1) * 8 +: 8] = word[15:8];
      end
      case (health)
         HLTH_WORN: begin
            image[FBAD_POS*8 +: 8] = 8'hFF;
            image[RBAD_POS*8 +: 8] = 8'h00;
         end
         HLTH_FACTORY: begin
            image[FBAD_POS*8 +: 8] = 8'h00;
            image[RBAD_POS*8 +: 8] = 8'h00;
         end
         default: begin
            image[FBAD_POS*8 +: 8] = 8'hFF;
            image[RBAD_POS*8 +: 8] = 8'hFF;
         end
      endcase
   end

   always_comb begin
      AST_ENC_FACTORY_BOTH: assert (!(image[FBAD_POS*8 +: 8] == 8'h00 &&
                                      image[RBAD_POS*8 +: 8] != 8'h00)); // R9
      AST_ENC_COPIES_EQUAL: assert (image[TAG_BASE*8 +: 16] ==
                                    image[(TAG_BASE+4)*8 +: 16]); // R8
   end
endmodule

// File: rtl/blk_tag_codec.sv
module blk_tag_codec
   import sat_pkg::*;
#(
   parameter int OOB_BYTES = 16,
   parameter int FBAD_POS  = 5,
   parameter int RBAD_POS  = 4,
   parameter int GOOD_MIN  = 7,
   localparam int IDX_W    = $clog2(OOB_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dec_start,
   input  logic                   dec_valid,
   input  logic [IDX_W-1:0]       dec_idx,
   input  logic [7:0]             dec_data,
   input  logic                   dec_last,
   output logic                   dec_busy,
   output logic                   dec_done,
   output logic [1:0]             dec_health,
   output logic                   dec_invalid,
   output logic                   dec_unassigned,
   output logic [LOGNO_W-1:0]     dec_logno,
   input  logic [1:0]             enc_health,
   input  logic [LOGNO_W-1:0]     enc_logno,
   output logic [OOB_BYTES*8-1:0] enc_image
);
   localparam int TAG_END = TAG_BASE + 2 * TAG_COPIES;

   if (OOB_BYTES < TAG_END) begin : g_bad_size
      $error("blk_tag_codec: spare area too small for the tag copies");
   end
   if (FBAD_POS == RBAD_POS) begin : g_bad_same
      $error("blk_tag_codec: health byte positions must differ");
   end
   for (genvar p = 0; p < 2; p++) begin : g_pos_chk
      localparam int POS = (p == 0) ? FBAD_POS : RBAD_POS;
      if (POS < 0 || POS >= OOB_BYTES || POS <= 3 || POS == 6 || POS == 7 ||
          (POS >= TAG_BASE && POS < TAG_END)) begin : g_bad_pos
         $error("blk_tag_codec: health byte position collides or is out of range");
      end
   end

   sat_tag_decoder #(
      .OOB_BYTES (OOB_BYTES),
      .FBAD_POS  (FBAD_POS),
      .RBAD_POS  (RBAD_POS),
      .GOOD_MIN  (GOOD_MIN)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (dec_start),
      .valid      (dec_valid),
      .idx        (dec_idx),
      .data       (dec_data),
      .last       (dec_last),
      .busy       (dec_busy),
      .done       (dec_done),
      .health     (dec_health),
      .invalid    (dec_invalid),
      .unassigned (dec_unassigned),
      .logno      (dec_logno)
   );

   sat_tag_encoder #(
      .OOB_BYTES (OOB_BYTES),
      .FBAD_POS  (FBAD_POS),
      .RBAD_POS  (RBAD_POS)
   ) u_enc (
      .health (enc_health),
      .logno  (enc_logno),
      .image  (enc_image)
   );
endmodule

// File: tb/tb_blk_tag_codec.sv
`timescale 1ns/1ps
module tb_blk_tag_codec;
   localparam int NB = 16;
   localparam int FB = 5;
   localparam int RB = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dec_start = 1'b0;
   logic         dec_valid = 1'b0;
   logic [3:0]   dec_idx = '0;
   logic [7:0]   dec_data = '0;
   logic         dec_last = 1'b0;
   logic         dec_busy, dec_done, dec_invalid, dec_unassigned;
   logic [1:0]   dec_health;
   logic [9:0]   dec_logno;
   logic [1:0]   enc_health = '0;
   logic [9:0]   enc_logno = '0;
   logic [127:0] enc_image;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   blk_tag_codec dut (
      .clk(clk), .rst_n(rst_n),
      .dec_start(dec_start), .dec_valid(dec_valid), .dec_idx(dec_idx),
      .dec_data(dec_data), .dec_last(dec_last), .dec_busy(dec_busy),
      .dec_done(dec_done), .dec_health(dec_health), .dec_invalid(dec_invalid),
      .dec_unassigned(dec_unassigned), .dec_logno(dec_logno),
      .enc_health(enc_health), .enc_logno(enc_logno), .enc_image(enc_image)
   );

   // vector: {copy0, copy1, copy2, fbad byte, rbad byte, health, invalid, unassigned, logno}
   localparam int NV = 12;
   localparam logic [77:0] VEC [NV] = '{
      {16'h12AA, 16'h12AA, 16'h12AA, 8'hFF, 8'hFF, 2'd0, 1'b0, 1'b0, 10'h155}, // R1 all agree
      {16'h1002, 16'h1002, 16'h12AA, 8'hFF, 8'hFF, 2'd0, 1'b0, 1'b0, 10'h001}, // R1 pair 0-1
      {16'h12AA, 16'h1007, 16'h1007, 8'hFF, 8'hFF, 2'd0, 1'b0, 1'b0, 10'h003}, // R1 pair 1-2
      {16'h17FF, 16'h1002, 16'h17FF, 8'hFF, 8'hFF, 2'd0, 1'b0, 1'b0, 10'h3FF}, // R1 pair 2-0
      {16'h1001, 16'h1002, 16'h1007, 8'hFF, 8'hFF, 2'd0, 1'b1, 1'b0, 10'h000}, // R1 no pair
      {16'h1003, 16'h1003, 16'h1003, 8'hFF, 8'hFF, 2'd0, 1'b1, 1'b0, 10'h000}, // R2 odd parity
      {16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFE, 8'hFF, 2'd0, 1'b0, 1'b1, 10'h000}, // R3 R4 seven ones
      {16'h1001, 16'h1001, 16'h1001, 8'hFC, 8'h00, 2'd2, 1'b0, 1'b0, 10'h000}, // R4 R5 six ones
      {16'h1001, 16'h1001, 16'h1001, 8'hFF, 8'hF0, 2'd1, 1'b0, 1'b0, 10'h000}, // R5 runtime
      {16'h0006, 16'h0006, 16'h0006, 8'h00, 8'hFF, 2'd2, 1'b0, 1'b0, 10'h003}, // R3 R5 no mark
      {16'hFFFC, 16'hFFFC, 16'hFFFC, 8'h7F, 8'hBF, 2'd0, 1'b0, 1'b0, 10'h3FE}, // R3 high junk
      {16'hFFFF, 16'h12AA, 16'hFFFF, 8'hFF, 8'hEF, 2'd0, 1'b0, 1'b1, 10'h000}  // R3 via 2-0
   };

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input logic [15:0] c0, input logic [15:0] c1,
                                       input logic [15:0] c2, input logic [7:0] fb,
                                       input logic [7:0] rb);
      logic [127:0] b = {NB{8'h5A}};
      b[64 +: 16] = c0;
      b[80 +: 16] = c1;
      b[96 +: 16] = c2;
      b[FB*8 +: 8] = fb;
      b[RB*8 +: 8] = rb;
      return b;
   endfunction

   function automatic logic [15:0] tag_word(input logic [9:0] n);
      logic [15:0] w = 16'h1000 | {5'd0, n, 1'b0};
      w[0] = ^w;
      return w;
   endfunction

   task automatic open_frame();
      @(negedge clk) dec_start = 1'b1;
      @(negedge clk) dec_start = 1'b0;
   endtask

   task automatic send_byte(input int k, input logic [7:0] d, input bit lst);
      dec_valid = 1'b1;
      dec_idx   = k[3:0];
      dec_data  = d;
      dec_last  = lst;
      @(negedge clk);
      dec_valid = 1'b0;
      dec_last  = 1'b0;
   endtask

   // sends a full frame, checks done timing, leaves results sampled in the done cycle
   task automatic run_frame(input logic [127:0] b, input bit rev, input string tag,
                            output logic [13:0] res);
      bit early, on, after;
      open_frame();
      for (int n = 0; n < NB; n++) begin
         int k = rev ? (NB - 1 - n) : n;
         send_byte(k, b[k*8 +: 8], n == NB - 1);
      end
      early = dec_done;
      @(negedge clk);
      on  = dec_done;
      res = {dec_health, dec_invalid, dec_unassigned, dec_logno};
      @(negedge clk);
      after = dec_done;
      chk(!early && on && !after, {"R6 done pulse ", tag}, {early, on, after}, 3'b010);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [13:0] res;
      logic [13:0] held;
      bit seen;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({dec_busy, dec_done, dec_health, dec_invalid, dec_unassigned, dec_logno} == '0,
          "R11 reset", {dec_busy, dec_done, dec_health, dec_invalid, dec_unassigned, dec_logno}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dec_busy == 1'b0 && dec_done == 1'b0, "R11 after release", {dec_busy, dec_done}, 0);

      // table walk: R1 R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         logic [77:0] e = VEC[v];
         run_frame(mk(e[77:62], e[61:46], e[45:30], e[29:22], e[21:14]), 1'b0, "table", res);
         chk(res == e[13:0], $sformatf("R1 R2 R3 R4 R5 vector %0d", v), res, e[13:0]);
      end

      // R1 reverse byte order
      run_frame(mk(16'h12AA, 16'h12AA, 16'h12AA, 8'hFF, 8'hFF), 1'b1, "reverse", res);
      chk(res == {2'd0, 1'b0, 1'b0, 10'h155}, "R1 reverse order", res, {2'd0, 1'b0, 1'b0, 10'h155});

      // R7 bytes with no open frame are ignored
      held = {dec_health, dec_invalid, dec_unassigned, dec_logno};
      seen = 1'b0;
      for (int k = 4; k < 14; k++) begin
         send_byte(k, 8'h00, k == 13);
         seen |= dec_done;
      end
      repeat (3) begin
         @(negedge clk);
         seen |= dec_done;
      end
      chk(!seen, "R7 no done outside frame", seen, 0);
      chk({dec_health, dec_invalid, dec_unassigned, dec_logno} == held, "R7 results unchanged",
          {dec_health, dec_invalid, dec_unassigned, dec_logno}, held);

      // R7 undelivered bytes count as 0xFF
      open_frame();
      send_byte(15, 8'h00, 1'b1);
      @(negedge clk);
      res = {dec_health, dec_invalid, dec_unassigned, dec_logno};
      chk(dec_done && res == {2'd0, 1'b0, 1'b1, 10'd0}, "R7 missing bytes",
          {dec_done, res}, {1'b1, 2'd0, 1'b0, 1'b1, 10'd0});
      @(negedge clk);

      // R6 restart discards partial frame
      open_frame();
      for (int k = 8; k < 14; k++) send_byte(k, 8'h00, 1'b0);
      send_byte(5, 8'h00, 1'b0);
      chk(dec_busy == 1'b1, "R6 busy in frame", dec_busy, 1);
      open_frame();
      send_byte(15, 8'h00, 1'b1);
      chk(dec_busy == 1'b0, "R6 busy clears after last", dec_busy, 0);
      @(negedge clk);
      res = {dec_health, dec_invalid, dec_unassigned, dec_logno};
      chk(res == {2'd0, 1'b0, 1'b1, 10'd0}, "R6 restart", res, {2'd0, 1'b0, 1'b1, 10'd0});
      @(negedge clk);

      // encoder: R8 R9 R10, then round trip through the decoder
      for (int h = 0; h < 4; h++) begin
         logic [9:0] n;
         logic [127:0] exp;
         logic [15:0] w;
         logic [1:0] eh;
         n = (h == 0) ? 10'h155 : (h == 1) ? 10'h000 : (h == 2) ? 10'h3FF : 10'h2A5;
         w = tag_word(n);
         exp = '1;
         exp[64 +: 16] = w;
         exp[80 +: 16] = w;
         exp[96 +: 16] = w;
         if (h == 1) exp[RB*8 +: 8] = 8'h00;
         if (h == 2) begin
            exp[FB*8 +: 8] = 8'h00;
            exp[RB*8 +: 8] = 8'h00;
         end
         @(negedge clk);
         enc_health = h[1:0];
         enc_logno  = n;
         #1;
         chk(enc_image == exp, $sformatf("R8 R9 R10 encode code %0d", h), enc_image, exp);
         eh = (h == 3) ? 2'd0 : h[1:0];
         run_frame(enc_image, 1'b0, "roundtrip", res);
         chk(res == {eh, 1'b0, 1'b0, n}, "R8 R9 round trip", res, {eh, 1'b0, 1'b0, n});
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule